// File: doc/BRIEF.md
# Transceiver Bring-up Sequencer over APB

This block brings a multi-gigabit transceiver from power-up to a running link without software help. On a start pulse it walks a small computed table of address/data pairs and writes each pair to the transceiver through its own APB master. It then pulses a shared receive reset to every lane for a fixed hold time. After that it waits for three lock indications in order: clock-data-recovery frequency lock, then coarse phase lock, then fine phase lock.

Each lock stage gives up after a programmable number of cycles. When a stage gives up, the sequencer repeats the receive reset and counts one retry. Once all three stages have locked, the sequencer polls a single status register forever. It publishes each value it reads and pulses a strobe with each new value.

Top module: `xcvr_boot_seq`

## Requirements
- R1: After a synchronous reset, psel, penable, init_done, locked, status_upd, every lane_rst bit and retry_cnt are 0. No bus transfer starts until start is pulsed while the block is idle.
- R2: After start, exactly ROM_DEPTH single APB writes are issued in index order. Entry i goes to address CFG_BASE + 4*i (defaults 0x100, 16 entries). Its data is {0xA5, i[7:0], ~i[7:0], i[7:0]^0x3C}.
- R3: Every transfer has exactly one setup cycle (psel=1, penable=0) and then access cycles (psel=1, penable=1). The access cycles repeat until pready is 1. paddr, pwrite and pwdata hold still for the whole transfer, and psel drops after the completing cycle.
- R4: init_done goes high only after the last table write has completed, and it then stays high until reset.
- R5: After the table, all lane_rst bits rise together and stay high for exactly HOLD_CYC cycles (default 64). No bus transfer happens while they are high.
- R6: The lock stages are taken strictly in the order frequency, coarse, fine. A lock input for a later stage has no effect while an earlier stage is waiting.
- R7: A stage counts its cycles from 0. If its lock input is still low when the count equals lock_timeout, the block repeats the full receive-reset pulse. retry_cnt then rises by exactly 1, and it saturates at its maximum value.
- R8: After the fine lock, locked stays at 1. From then on the block only issues reads, all to STATUS_ADDR, separated by REFRESH_GAP idle cycles.
- R9: Each completed status read is published on status_word. status_upd is high for exactly one cycle with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the bring-up when idle |
| lock_timeout | input | TO_W | Cycle limit for each lock stage |
| freq_lock | input | 1 | CDR frequency lock indication |
| coarse_lock | input | 1 | CDR coarse phase lock indication |
| fine_lock | input | 1 | CDR fine phase lock indication |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| pwrite | output | 1 | APB write select |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pready | input | 1 | APB ready from the transceiver |
| prdata | input | DATA_W | APB read data |
| lane_rst | output | LANES | Receive reset, one shared value on all lanes |
| init_done | output | 1 | Table written |
| locked | output | 1 | All three lock stages passed |
| status_word | output | DATA_W | Last status register value read |
| status_upd | output | 1 | One-cycle strobe with each new status value |
| retry_cnt | output | RETRY_W | Saturating count of lock timeouts |

## Verification
The assertions assume a slave that eventually raises pready, and a pready value that is meaningful only while psel and penable are both high. They also assume lock inputs that are plain levels sampled on the clock. The bench slave meets these assumptions. It drives pready only during access cycles and chooses it from a seeded random stream, so the wait states vary. It returns fresh random read data on every poll. Lock inputs change only on the falling edge, and lock_timeout stays constant, at or above 1, for the whole run.

// File: rtl/xcvr_boot_pkg.sv
package xcvr_boot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WRWAIT,
    ST_CFGDONE,
    ST_RXRST,
    ST_LOCK_FREQ,
    ST_LOCK_COARSE,
    ST_LOCK_FINE,
    ST_POLL_ISSUE,
    ST_POLL_WAIT,
    ST_POLL_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    AP_IDLE,
    AP_SETUP,
    AP_ACCESS
  } apb_phase_e;

  // Configuration word for table entry k
  function automatic logic [31:0] cfg_word(input int unsigned k);
    logic [7:0] b;
    b = 8'(k);
    return {8'hA5, b, ~b, b ^ 8'h3C};
  endfunction

endpackage

// File: rtl/xcvr_cfg_rom.sv
module xcvr_cfg_rom #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BASE   = 'h100,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  import xcvr_boot_pkg::*;

  // Registered lookup so the table maps onto a synchronous ROM
  always_ff @(posedge clk) begin
    addr_q <= ADDR_W'(BASE + 4 * int'(idx));
    data_q <= DATA_W'(cfg_word(int'(idx)));
  end

endmodule

// File: rtl/xcvr_apb_xfer.sv
module xcvr_apb_xfer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata
);
  import xcvr_boot_pkg::*;

  apb_phase_e ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= AP_IDLE;
      psel    <= 1'b0;
      penable <= 1'b0;
      pwrite  <= 1'b0;
      paddr   <= '0;
      pwdata  <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        AP_IDLE: begin
          if (req) begin
            psel    <= 1'b1;
            penable <= 1'b0;
            pwrite  <= req_wr;
            paddr   <= req_addr;
            pwdata  <= req_wr ? req_wdata : '0;
            ph      <= AP_SETUP;
          end
        end
        AP_SETUP: begin
          penable <= 1'b1;
          ph      <= AP_ACCESS;
        end
        AP_ACCESS: begin
          if (pready) begin
            psel    <= 1'b0;
            penable <= 1'b0;
            done    <= 1'b1;
            if (!pwrite) rdata <= prdata;
            ph      <= AP_IDLE;
          end
        end
        default: ph <= AP_IDLE;
      endcase
    end
  end

  AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (psel && penable)); // R3

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr)
                                      && $stable(pwrite) && $stable(pwdata))); // R3

  AST_RELEASE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pready) |=> (!psel && !penable)); // R3

  AST_ENABLE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    penable |-> psel); // R3

endmodule

// File: rtl/xcvr_cycle_cnt.sv
module xcvr_cycle_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != {W{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/xcvr_boot_seq.sv
module xcvr_boot_seq #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int ROM_DEPTH   = 16,
  parameter int CFG_BASE    = 'h100,
  parameter int STATUS_ADDR = 'h1FC,
  parameter int HOLD_CYC    = 64,
  parameter int REFRESH_GAP = 8,
  parameter int TO_W        = 12,
  parameter int RETRY_W     = 8,
  parameter int LANES       = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [TO_W-1:0]    lock_timeout,
  input  logic               freq_lock,
  input  logic               coarse_lock,
  input  logic               fine_lock,
  output logic [ADDR_W-1:0]  paddr,
  output logic [DATA_W-1:0]  pwdata,
  output logic               pwrite,
  output logic               psel,
  output logic               penable,
  input  logic               pready,
  input  logic [DATA_W-1:0]  prdata,
  output logic [LANES-1:0]   lane_rst,
  output logic               init_done,
  output logic               locked,
  output logic [DATA_W-1:0]  status_word,
  output logic               status_upd,
  output logic [RETRY_W-1:0] retry_cnt
);
  import xcvr_boot_pkg::*;

  localparam int IDX_W  = $clog2(ROM_DEPTH);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int GAP_W  = $clog2(REFRESH_GAP + 1);
  localparam int HG_W   = (HOLD_W > GAP_W) ? HOLD_W : GAP_W;
  localparam int CNT_W  = (HG_W > TO_W) ? HG_W : TO_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROM_DEPTH - 1);

  seq_state_e st, nxt;

  logic [IDX_W-1:0]   idx;
  logic [ADDR_W-1:0]  rom_addr;
  logic [DATA_W-1:0]  rom_data;
  logic               apb_req, apb_wr, apb_done;
  logic [ADDR_W-1:0]  apb_addr;
  logic [DATA_W-1:0]  apb_rdata;
  logic [CNT_W-1:0]   cyc;
  logic               cyc_clr;
  logic               rxrst_q;
  logic               stage_to;
  logic               hold_end;
  logic               gap_end;

  xcvr_cfg_rom #(
    .DEPTH (ROM_DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BASE  (CFG_BASE)
  ) u_rom (
    .clk   (clk),
    .idx   (idx),
    .addr_q(rom_addr),
    .data_q(rom_data)
  );

  assign apb_req  = (st == ST_ISSUE) || (st == ST_POLL_ISSUE);
  assign apb_wr   = (st == ST_ISSUE);
  assign apb_addr = apb_wr ? rom_addr : ADDR_W'(STATUS_ADDR);

  xcvr_apb_xfer #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_apb (
    .clk      (clk),
    .rst      (rst),
    .req      (apb_req),
    .req_wr   (apb_wr),
    .req_addr (apb_addr),
    .req_wdata(rom_data),
    .done     (apb_done),
    .rdata    (apb_rdata),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .pready   (pready),
    .prdata   (prdata)
  );

  xcvr_cycle_cnt #(.W(CNT_W)) u_cyc (
    .clk(clk),
    .rst(rst),
    .clr(cyc_clr),
    .cnt(cyc)
  );

  assign stage_to = (cyc >= CNT_W'(lock_timeout));
  assign hold_end = (cyc == CNT_W'(HOLD_CYC - 1));
  assign gap_end  = (cyc >= CNT_W'(REFRESH_GAP - 1));

  // Next-state decision
  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:        if (start) nxt = ST_FETCH;
      ST_FETCH:       nxt = ST_ISSUE;
      ST_ISSUE:       nxt = ST_WRWAIT;
      ST_WRWAIT:      if (apb_done) nxt = (idx == LAST_IDX) ? ST_CFGDONE : ST_FETCH;
      ST_CFGDONE:     nxt = ST_RXRST;
      ST_RXRST:       if (hold_end) nxt = ST_LOCK_FREQ;
      ST_LOCK_FREQ: begin
        if (freq_lock)     nxt = ST_LOCK_COARSE;
        else if (stage_to) nxt = ST_RXRST;
      end
      ST_LOCK_COARSE: begin
        if (coarse_lock)   nxt = ST_LOCK_FINE;
        else if (stage_to) nxt = ST_RXRST;
      end
      ST_LOCK_FINE: begin
        if (fine_lock)     nxt = ST_POLL_ISSUE;
        else if (stage_to) nxt = ST_RXRST;
      end
      ST_POLL_ISSUE:  nxt = ST_POLL_WAIT;
      ST_POLL_WAIT:   if (apb_done) nxt = ST_POLL_GAP;
      ST_POLL_GAP:    if (gap_end) nxt = ST_POLL_ISSUE;
      default:        nxt = ST_IDLE;
    endcase
  end

  // Every state starts counting from zero
  assign cyc_clr = (nxt != st);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      idx         <= '0;
      rxrst_q     <= 1'b0;
      init_done   <= 1'b0;
      locked      <= 1'b0;
      status_word <= '0;
      status_upd  <= 1'b0;
      retry_cnt   <= '0;
    end else begin
      st         <= nxt;
      rxrst_q    <= (nxt == ST_RXRST);
      status_upd <= 1'b0;
      if (st == ST_IDLE && start) idx <= '0;
      if (st == ST_WRWAIT && apb_done && idx != LAST_IDX) idx <= idx + 1'b1;
      if (nxt == ST_CFGDONE) init_done <= 1'b1;
      if (st == ST_LOCK_FINE && fine_lock) locked <= 1'b1;
      if ((st == ST_LOCK_FREQ || st == ST_LOCK_COARSE || st == ST_LOCK_FINE)
          && nxt == ST_RXRST && retry_cnt != {RETRY_W{1'b1}}) begin
        retry_cnt <= retry_cnt + 1'b1;
      end
      if (st == ST_POLL_WAIT && apb_done) begin
        status_word <= apb_rdata;
        status_upd  <= 1'b1;
      end
    end
  end

  // One register fans out to every lane reset
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_rst[g] = rxrst_q;
  end

  AST_NO_BUS_IN_RXRST: assert property (@(posedge clk) disable iff (rst)
    lane_rst[0] |-> !psel); // R5

  AST_INIT_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R4

  AST_RETRY_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(retry_cnt) |-> (retry_cnt == $past(retry_cnt) + 1'b1)); // R7

  AST_LOCKED_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
    locked |-> (init_done && !lane_rst[0])); // R8

  AST_NO_WRITE_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    (locked && psel) |-> !pwrite); // R8

  AST_UPDATE_IS_PULSE: assert property (@(posedge clk) disable iff (rst)
    status_upd |=> !status_upd); // R9

endmodule

// File: tb/xcvr_boot_seq_tb.sv
module xcvr_boot_seq_tb;

  localparam int AW      = 16;
  localparam int DW      = 32;
  localparam int DEPTH   = 16;
  localparam int HOLD    = 64;
  localparam int RW      = 3;
  localparam int LN      = 4;
  localparam int STAT_A  = 'h1FC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [11:0] lock_timeout = 12'd20;
  logic freq_lock = 1'b0, coarse_lock = 1'b0, fine_lock = 1'b0;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata, prdata = '0;
  logic pwrite, psel, penable, pready = 1'b0;
  logic [LN-1:0] lane_rst;
  logic init_done, locked, status_upd;
  logic [DW-1:0] status_word;
  logic [RW-1:0] retry_cnt;

  always #10 clk = ~clk;

  xcvr_boot_seq #(.RETRY_W(RW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .lock_timeout(lock_timeout),
    .freq_lock(freq_lock), .coarse_lock(coarse_lock), .fine_lock(fine_lock),
    .paddr(paddr), .pwdata(pwdata), .pwrite(pwrite), .psel(psel),
    .penable(penable), .pready(pready), .prdata(prdata),
    .lane_rst(lane_rst), .init_done(init_done), .locked(locked),
    .status_word(status_word), .status_upd(status_upd), .retry_cnt(retry_cnt)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input int k);
    return AW'('h100 + 4 * k);
  endfunction

  function automatic logic [DW-1:0] exp_data(input int k);
    logic [7:0] b;
    b = 8'(k);
    return {8'hA5, b, ~b, b ^ 8'h3C};
  endfunction

  // Slave model and monitors, all on the falling edge
  logic [AW-1:0] wr_a [DEPTH];
  logic [DW-1:0] wr_d [DEPTH];
  int wr_n = 0, rd_n = 0, xfer_n = 0, bad_rd = 0, wr_after_lock = 0;
  int setup_viol = 0, lane_mis = 0, run = 0, pulses = 0, last_width = 0;
  int stat_mis = 0, upd_n = 0;
  logic [DW-1:0] last_rd = '0;
  bit prev_setup = 0, in_access = 0;

  always @(negedge clk) begin
    if (rst) begin
      pready = 1'b0;
      prev_setup = 0;
      in_access = 0;
    end else begin
      if (psel && penable) begin
        if (!in_access && !prev_setup) setup_viol++;
        in_access = 1;
        pready = ($urandom % 3) != 0;
        if (pready) begin
          xfer_n++;
          if (pwrite) begin
            if (wr_n < DEPTH) begin
              wr_a[wr_n] = paddr;
              wr_d[wr_n] = pwdata;
            end
            wr_n++;
            if (locked) wr_after_lock++;
          end else begin
            prdata = $urandom;
            last_rd = prdata;
            rd_n++;
            if (paddr != AW'(STAT_A)) bad_rd++;
          end
        end
      end else begin
        pready = 1'b0;
        if (!psel) in_access = 0;
      end
      prev_setup = psel && !penable;

      if (lane_rst != '0 && lane_rst != '1) lane_mis++;
      if (lane_rst[0]) run++;
      else if (run > 0) begin
        last_width = run;
        pulses++;
        run = 0;
      end

      if (status_upd) begin
        upd_n++;
        if (status_word != last_rd) stat_mis++;
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    // R1 reset state
    check(!psel && !penable, "R1 bus idle", {psel, penable}, 0);
    check(!init_done && !locked && !status_upd, "R1 flags", {init_done, locked, status_upd}, 0);
    check(lane_rst == '0 && retry_cnt == '0, "R1 lanes/retry", {lane_rst, retry_cnt}, 0);
    wait_cyc(20);
    check(xfer_n == 0, "R1 no transfer before start", xfer_n, 0);

    start = 1'b1;
    wait_cyc(1);
    start = 1'b0;

    for (int i = 0; i < 2000 && !init_done; i++) wait_cyc(1);
    // R4 completion only after the last write
    check(init_done && wr_n == DEPTH, "R4 done after table", wr_n, DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      check(wr_a[k] == exp_addr(k) && wr_d[k] == exp_data(k), $sformatf("R2 entry %0d", k),
            {wr_a[k], wr_d[k]}, {exp_addr(k), exp_data(k)});
    end
    check(setup_viol == 0, "R3 setup before access", setup_viol, 0);

    // R5 first receive reset pulse
    for (int i = 0; i < 500 && pulses == 0; i++) wait_cyc(1);
    check(last_width == HOLD, "R5 hold width", last_width, HOLD);
    check(lane_mis == 0, "R5 lanes tied", lane_mis, 0);

    // R7 timeouts with all locks low
    for (int i = 0; i < 500 && retry_cnt == 0; i++) wait_cyc(1);
    check(retry_cnt == 1, "R7 first retry", retry_cnt, 1);
    wait_cyc(2);
    check(lane_rst == '1, "R7 reset reasserted", lane_rst, 4'hF);
    wait_cyc(1500);
    check(retry_cnt == '1, "R7 retry saturates", retry_cnt, 7);
    check(last_width == HOLD && pulses > 8, "R7 full hold per retry", last_width, HOLD);
    check(xfer_n == DEPTH, "R5 no bus during retries", xfer_n, DEPTH);
    check(init_done, "R4 done stays high", init_done, 1);

    // R6 later-stage locks are ignored while an earlier one waits
    coarse_lock = 1'b1;
    fine_lock = 1'b1;
    wait_cyc(400);
    check(!locked, "R6 coarse/fine ignored without freq", locked, 0);
    freq_lock = 1'b1;
    coarse_lock = 1'b0;
    wait_cyc(400);
    check(!locked, "R6 fine ignored without coarse", locked, 0);
    coarse_lock = 1'b1;
    for (int i = 0; i < 400 && !locked; i++) wait_cyc(1);
    check(locked, "R6 lock after all three", locked, 1);

    // R8/R9 status polling
    for (int i = 0; i < 3000 && rd_n < 12; i++) wait_cyc(1);
    wait_cyc(4);
    check(rd_n >= 12, "R8 periodic reads", rd_n, 12);
    check(bad_rd == 0 && wr_after_lock == 0, "R8 only status reads", bad_rd + wr_after_lock, 0);
    check(locked && lane_rst == '0, "R8 locked holds", locked, 1);
    check(stat_mis == 0, "R9 status matches read", stat_mis, 0);
    check(upd_n == rd_n, "R9 one strobe per read", upd_n, rd_n);
    check(setup_viol == 0, "R3 setup before access in polling", setup_viol, 0);

    freq_lock = 1'b0;
    coarse_lock = 1'b0;
    fine_lock = 1'b0;
    wait_cyc(100);
    check(locked && wr_after_lock == 0, "R8 lock inputs dropped", locked, 1);
    finish_run();
  end

endmodule